// File: doc/BRIEF.md
# Host Memory Access Port

This block is a slave port through which an external host reads and writes the on-chip program memory (24-bit words) and data memory (16-bit words) over a 16-bit bus. The host drives a select line together with one of three strobes: an address-latch strobe, a read strobe or a write strobe. All of them are sampled on the rising clock edge. An address-latch strobe captures a control word. With bit 15 clear, the word loads a start address and a memory-space select. With bit 15 set, it loads the overlay bank numbers. Read and write strobes then move one host word each between the bus and internal memory at the current address, and the address steps forward automatically.

The host data path works as a valid/ready stream. A data strobe under select is the valid side and `host_ack` is the ready side. A strobe counts only in a cycle where `host_ack` is high. Each accepted data word takes exactly one internal cycle, during which `host_ack` is low. Strobes seen in that cycle are dropped, so the host must wait for `host_ack` and then issue the strobe again. Read data appears on `host_dout` when `host_ack` returns high, and it holds until the next completed read.

The internal memories are arrays of 2^(BANK_W+IDX_W) words. A program-memory word moves as two host accesses. Data-memory addresses in the control-register window are protected from host writes.

Top module: `host_mem_port`

## Requirements
- R1: After reset, `host_ack` is 1 and `host_dout` is 0. The current address is 0, the space is data memory, both bank numbers are 0, and the program-memory half pointer is on the upper half.
- R2: A latch (`host_sel` and `host_latch` with `host_ack` high) of a word with bit 15 = 0 does three things. It loads the address from bits 13..0. It selects program memory if bit 14 = 1 and data memory if bit 14 = 0. It points the program-memory half pointer at the upper half.
- R3: A latch of a word with bit 15 = 1 and bits 14..8 all zero loads the program-memory bank from bits BANK_W-1..0 and the data-memory bank from bits 4+BANK_W-1..4. The address, space and half pointer are left unchanged.
- R4: A latch of a word with bit 15 = 1 and any of bits 14..8 nonzero changes nothing.
- R5: A data strobe is accepted when `host_sel` is high, `host_latch` is low, `host_rd` or `host_wr` is high, and `host_ack` is high. After acceptance, `host_ack` is low for exactly the next cycle, and the access completes at the end of that cycle. If both strobes are high, the access is a write.
- R6: Strobes of any kind in a cycle where `host_ack` is low are ignored.
- R7: In data memory, a write stores the 16-bit bus word and a read returns the stored word. `host_dout` changes only at the end of a read's busy cycle. The address increments by 1 after every access.
- R8: In program memory, the first access of a pair carries word bits 23..8 and the second carries bits 7..0 on bus bits 7..0. Reads return 0 in bus bits 15..8 for the second half. The word is written when the second half completes, and the address increments after the second half only.
- R9: The memory index is {bank, address bits IDX_W-1..0}, so equal addresses in different banks reach different words.
- R10: Data-memory addresses at or above CTRL_BASE (default 0x3FE0) are control registers. Writes to them are discarded and do not touch the aliased array word, and reads of them return 0.
- R11: When `host_latch` and a data strobe are high together under select, only the latch takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Port select from host |
| host_latch | input | 1 | Control-word latch strobe |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_din | input | 16 | Control or write word from host |
| host_dout | output | 16 | Read word to host |
| host_ack | output | 1 | High when the port can accept a strobe |

## Verification
A wrong address, space, bank or half-pointer state shows at the ports on the next completed read. That read returns a word other than the one written, or it returns a control-window 0 in place of data, so the error appears within two cycles of the read strobe. A wrong busy state shows at once as `host_ack` held low for zero or two cycles after an accepted strobe. A behavioural model in the bench is compared against `host_ack` and `host_dout` on every cycle, so a divergence is seen in the cycle it occurs.

// File: rtl/hap_pkg.sv
package hap_pkg;
  localparam int unsigned CW_ADDR_W = 14;

  typedef enum logic [1:0] {
    CW_SET_ADDR = 2'd0,
    CW_SET_BANK = 2'd1,
    CW_DROP     = 2'd2
  } cw_kind_e;

  typedef struct packed {
    cw_kind_e               kind;
    logic                   to_pm;
    logic [CW_ADDR_W-1:0]   addr;
    logic [7:0]             bank;
  } cw_t;
endpackage

// File: rtl/hap_cw_decode.sv
module hap_cw_decode
  import hap_pkg::*;
(
  input  logic [15:0] word,
  output cw_t         cw
);
  always_comb begin
    cw.addr  = word[CW_ADDR_W-1:0];
    cw.to_pm = word[14];
    cw.bank  = word[7:0];
    if (!word[15])
      cw.kind = CW_SET_ADDR;
    else if (word[14:8] == 7'd0)
      cw.kind = CW_SET_BANK;
    else
      cw.kind = CW_DROP;
  end
endmodule

// File: rtl/hap_seq.sv
module hap_seq
  import hap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 latch,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [15:0]          din,
  input  cw_t                  cw,
  output logic                 busy_q,
  output logic                 wr_q,
  output logic [15:0]          din_q,
  output logic [CW_ADDR_W-1:0] addr_q,
  output logic                 pm_q,
  output logic [7:0]           ovl_q,
  output logic                 half_q
);
  logic acc_go, lat_go;

  assign lat_go = sel & latch & ~busy_q;
  assign acc_go = sel & ~latch & (rd | wr) & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      din_q  <= '0;
      addr_q <= '0;
      pm_q   <= 1'b0;
      ovl_q  <= '0;
      half_q <= 1'b0;
    end else begin
      busy_q <= acc_go;
      if (acc_go) begin
        wr_q  <= wr;
        din_q <= din;
      end
      if (busy_q) begin
        if (pm_q) begin
          half_q <= ~half_q;
          if (half_q) addr_q <= addr_q + 1'b1;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end
      if (lat_go) begin
        case (cw.kind)
          CW_SET_ADDR: begin
            addr_q <= cw.addr;
            pm_q   <= cw.to_pm;
            half_q <= 1'b0;
          end
          CW_SET_BANK: ovl_q <= cw.bank;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hap_mem.sv
module hap_mem #(
  parameter int unsigned W  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hap_pkg::*;
#(
  parameter int unsigned          IDX_W     = 6,
  parameter int unsigned          BANK_W    = 2,
  parameter int unsigned          PM_W      = 24,
  parameter int unsigned          DM_W      = 16,
  parameter logic [CW_ADDR_W-1:0] CTRL_BASE = 14'h3FE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_latch,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [15:0] host_din,
  output logic [15:0] host_dout,
  output logic        host_ack
);
  localparam int unsigned MEM_AW = BANK_W + IDX_W;
  localparam int unsigned LO_W   = PM_W - 16;

  cw_t                  cw;
  logic                 busy_q, wr_q, pm_q, half_q;
  logic [15:0]          din_q;
  logic [CW_ADDR_W-1:0] addr_q;
  logic [7:0]           ovl_q;
  logic [15:0]          stage_q;
  logic [MEM_AW-1:0]    pm_idx, dm_idx;
  logic [PM_W-1:0]      pm_rd, pm_wdata;
  logic [DM_W-1:0]      dm_rd;
  logic                 pm_we, dm_we, ctrl_hit;
  logic                 unused_ovl;

  hap_cw_decode u_dec (.word(host_din), .cw(cw));

  hap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .latch(host_latch),
    .rd(host_rd), .wr(host_wr), .din(host_din), .cw(cw),
    .busy_q(busy_q), .wr_q(wr_q), .din_q(din_q), .addr_q(addr_q),
    .pm_q(pm_q), .ovl_q(ovl_q), .half_q(half_q)
  );

  assign unused_ovl = ^ovl_q;
  assign pm_idx   = {ovl_q[BANK_W-1:0], addr_q[IDX_W-1:0]};
  assign dm_idx   = {ovl_q[4 +: BANK_W], addr_q[IDX_W-1:0]};
  assign ctrl_hit = (addr_q >= CTRL_BASE);
  assign pm_we    = busy_q & wr_q & pm_q & half_q;
  assign dm_we    = busy_q & wr_q & ~pm_q & ~ctrl_hit;
  assign pm_wdata = {stage_q, din_q[LO_W-1:0]};

  hap_mem #(.W(PM_W), .AW(MEM_AW)) u_pm (
    .clk(clk), .we(pm_we), .waddr(pm_idx), .wdata(pm_wdata),
    .raddr(pm_idx), .rdata(pm_rd)
  );

  hap_mem #(.W(DM_W), .AW(MEM_AW)) u_dm (
    .clk(clk), .we(dm_we), .waddr(dm_idx), .wdata(din_q),
    .raddr(dm_idx), .rdata(dm_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      host_dout <= '0;
    end else if (busy_q) begin
      if (wr_q && pm_q && !half_q) stage_q <= din_q;
      if (!wr_q) begin
        if (pm_q)
          host_dout <= half_q ? {{(16-LO_W){1'b0}}, pm_rd[LO_W-1:0]}
                              : pm_rd[PM_W-1:LO_W];
        else
          host_dout <= ctrl_hit ? '0 : dm_rd;
      end
    end
  end

  assign host_ack = ~busy_q;
endmodule

// File: rtl/hap_checker.sv
module hap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_latch,
  input logic        host_rd,
  input logic        host_wr,
  input logic [15:0] host_din,
  input logic [15:0] host_dout,
  input logic        host_ack,
  input logic [13:0] addr_q
);
  assert_busy_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ack |=> host_ack);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_latch && (host_rd || host_wr) && host_ack) |=> !host_ack);

  assert_drop_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ack && host_sel && (host_rd || host_wr || host_latch)) |=> host_ack);

  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> $stable(host_dout));

  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_latch && host_ack && !host_din[15]) |=> addr_q == $past(host_din[13:0]));

  assert_bad_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_latch && host_ack && host_din[15] && (host_din[14:8] != 7'd0))
      |=> $stable(addr_q));
endmodule

bind host_mem_port hap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_latch(host_latch),
  .host_rd(host_rd), .host_wr(host_wr), .host_din(host_din),
  .host_dout(host_dout), .host_ack(host_ack), .addr_q(addr_q)
);

// File: tb/host_mem_port_test.sv
module host_mem_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, lat = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        ack;

  host_mem_port uut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_latch(lat),
    .host_rd(rd), .host_wr(wr), .host_din(din), .host_dout(dout), .host_ack(ack)
  );

  always #2 clk = ~clk;

  int    n_vec = 0, n_bad = 0;
  string req = "R1";
  bit    started = 0;

  int pm_m [256];
  int dm_m [256];
  int m_busy, m_wr, m_din, m_addr, m_pm, m_pb, m_db, m_ph, m_stage, m_dout;
  int was_busy, idx;

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_din = 0; m_addr = 0; m_pm = 0;
      m_pb = 0; m_db = 0; m_ph = 0; m_stage = 0; m_dout = 0;
    end else begin
      was_busy = m_busy;
      if (m_busy != 0) begin
        if (m_pm != 0) begin
          idx = m_pb * 64 + (m_addr % 64);
          if (m_wr != 0) begin
            if (m_ph == 0) m_stage = m_din;
            else pm_m[idx] = m_stage * 256 + (m_din % 256);
          end else begin
            m_dout = (m_ph == 0) ? (pm_m[idx] / 256) : (pm_m[idx] % 256);
          end
          if (m_ph == 1) m_addr = (m_addr + 1) % 16384;
          m_ph = 1 - m_ph;
        end else begin
          idx = m_db * 64 + (m_addr % 64);
          if (m_wr != 0) begin
            if (m_addr < 'h3FE0) dm_m[idx] = m_din;
          end else begin
            m_dout = (m_addr >= 'h3FE0) ? 0 : dm_m[idx];
          end
          m_addr = (m_addr + 1) % 16384;
        end
        m_busy = 0;
      end
      if (was_busy == 0 && sel) begin
        if (lat) begin
          if (!din[15]) begin
            m_addr = int'(din[13:0]); m_pm = int'(din[14]); m_ph = 0;
          end else if (din[14:8] == 7'd0) begin
            m_pb = int'(din[1:0]); m_db = int'(din[5:4]);
          end
        end else if (rd || wr) begin
          m_busy = 1; m_wr = wr ? 1 : 0; m_din = int'(din);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_vec++;
      if (ack !== (m_busy == 0) || dout !== m_dout[15:0]) begin
        n_bad++;
        $display("FAIL %s: ack=%0b dout=%h expected ack=%0b dout=%h",
                 req, ack, dout, (m_busy == 0), m_dout[15:0]);
      end
    end
  end

  task automatic cyc(input logic s, input logic l, input logic r, input logic w,
                     input logic [15:0] d);
    @(negedge clk);
    sel = s; lat = l; rd = r; wr = w; din = d;
  endtask
  task automatic idle(); cyc(0, 0, 0, 0, 16'h0); endtask
  task automatic latch(input logic [15:0] d); cyc(1, 1, 0, 0, d); endtask
  task automatic hwr(input logic [15:0] d); cyc(1, 0, 0, 1, d); idle(); endtask
  task automatic hrd(); cyc(1, 0, 1, 0, 16'h0); idle(); endtask
  task automatic expect_rd(input logic [15:0] e);
    hrd();
    @(negedge clk);
    n_vec++;
    if (dout !== e) begin
      n_bad++;
      $display("FAIL %s: dout=%h expected %h", req, dout, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle();
    @(negedge clk);
    n_vec++;
    if (ack !== 1'b1 || dout !== 16'h0) begin
      n_bad++;
      $display("FAIL R1: ack=%0b dout=%h expected 1 0000", ack, dout);
    end

    req = "R7"; latch(16'h0005); hwr(16'h1111); hwr(16'h2222);
    req = "R2"; latch(16'h0005);
    req = "R7"; expect_rd(16'h1111); expect_rd(16'h2222);

    req = "R8"; latch(16'h4010);
    hwr(16'hABCD); hwr(16'h00EF); hwr(16'h1234); hwr(16'h0056);
    latch(16'h4010);
    expect_rd(16'hABCD); expect_rd(16'h00EF); expect_rd(16'h1234); expect_rd(16'h0056);

    req = "R3"; latch(16'h8011); latch(16'h0005); hwr(16'h5555);
    req = "R9"; latch(16'h8000); latch(16'h0005); expect_rd(16'h1111);
    latch(16'h8010); latch(16'h0005); expect_rd(16'h5555);

    req = "R4"; latch(16'h8000); latch(16'h0005); latch(16'h8110);
    expect_rd(16'h1111);
    latch(16'h8110); expect_rd(16'h2222);

    req = "R10"; latch(16'h0020); hwr(16'h7777);
    latch(16'h3FE0); hwr(16'h9999); expect_rd(16'h0000);
    latch(16'h0020); expect_rd(16'h7777);

    req = "R6"; latch(16'h0030); hwr(16'h0001); hwr(16'h0002);
    latch(16'h0030);
    cyc(1, 0, 0, 1, 16'hAAAA);
    cyc(1, 0, 0, 1, 16'hBBBB);
    idle();
    latch(16'h0030); expect_rd(16'hAAAA); expect_rd(16'h0002);

    req = "R11"; latch(16'h0031);
    cyc(1, 1, 1, 0, 16'h0030); idle();
    req = "R5"; expect_rd(16'hAAAA);
    idle(); idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule